// File: doc/BRIEF.md
# Two-Clock Event Flag

This block holds a bank of event flags. Each flag is raised by an event in one clock domain and lowered from another clock domain, and neither domain needs a handshake to do it. Each flag is built from two flip-flops. One sits on the set-side clock and one sits on the read-side clock, and each has an enable from its own domain. The flag is the exclusive-OR of the two flops. An enabled set edge makes the flops disagree. An enabled clear edge makes them agree again.

The set-side clock does not have to be a free-running clock. A narrow strobe, even one shorter than a read-side clock period, can drive the set clock with the set enable held high, and the event is still latched. The raw exclusive-OR output changes asynchronously to the reader. For that reason a two-stage synchroniser in the read domain produces the copy that the read side uses. A clear request on a flag takes effect only once the synchronised copy of that flag is high. This stops a clear from wiping out an event that the reader has not yet seen.

Top module: `xdom_flag`

## Requirements
- R1: With set_rst and rd_rst both held high across clock edges of their domains, flag_raw and flag_sync are all zero.
- R2: A rising set_clk edge with set_en[i]=1 makes flag_raw[i]=1 right after that edge.
- R3: A set_clk edge with set_en[i]=0 leaves flag_raw[i] unchanged.
- R4: A second enabled set edge on a flag that is already raised leaves flag_raw[i]=1.
- R5: A rising rd_clk edge with clr_en[i]=1 while flag_sync[i]=1 makes flag_raw[i]=0 right after that edge.
- R6: A clear request on bit i is ignored while flag_sync[i]=0. This holds even when flag_raw[i] is already 1 but has not yet passed through the synchroniser.
- R7: flag_sync[i] equals flag_raw[i] as it was sampled two rd_clk rising edges earlier. A change on flag_raw is therefore visible on flag_sync no later than the third rd_clk edge.
- R8: Bit i of each vector controls only flag i. Other flags are not affected.
- R9: A set_clk pulse 1 ns wide, which is shorter than one rd_clk period, raises the flag when set_en is high.
- R10: An rd_clk edge with clr_en[i]=0 leaves flag_raw[i] unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| set_clk | input | 1 | Set-side clock, or a narrow event strobe |
| set_rst | input | 1 | Synchronous active-high reset, set domain |
| set_en | input | N | Per-flag set enable, set domain |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| clr_en | input | N | Per-flag clear request, read domain |
| flag_raw | output | N | Exclusive-OR of the two flops, asynchronous to rd_clk |
| flag_sync | output | N | flag_raw after two read-domain stages |

## Verification
With four flags, the bench walks every set mask against every clear mask. This shows that each bit answers only to its own enables and that masked-off bits stay put on both sides. A double set separates a true "make them differ" load from a plain toggle. A clear that arrives before the synchroniser has caught up shows whether the clear gating works. A 1 ns strobe on the set clock shows that events shorter than a read period are captured.

// File: rtl/xflag_pkg.sv
package xflag_pkg;

    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic set_q;
        logic clr_q;
    } flop_pair_t;

    function automatic logic pair_flag(input flop_pair_t p);
        return p.set_q ^ p.clr_q;
    endfunction

endpackage

// File: rtl/xflag_set_side.sv
module xflag_set_side #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en,
    input  logic [N-1:0] peer_q,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= 1'b0;
            else if (en[i]) q[i] <= ~peer_q[i];
        end
    end

    a_r1_set_reset: assert property (@(posedge clk) rst |=> q == '0);
    a_r2_set_differs: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((q ^ ~$past(peer_q)) & $past(en)) == '0);
    a_r3_set_hold: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((q ^ $past(q)) & ~$past(en)) == '0);
endmodule

// File: rtl/xflag_clr_side.sv
module xflag_clr_side #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en,
    input  logic [N-1:0] peer_q,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= 1'b0;
            else if (en[i]) q[i] <= peer_q[i];
        end
    end

    a_r1_clr_reset: assert property (@(posedge clk) rst |=> q == '0);
    a_r10_clr_hold: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((q ^ $past(q)) & ~$past(en)) == '0);
endmodule

// File: rtl/xflag_sync.sv
module xflag_sync #(
    parameter int unsigned N      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stage[s] <= '0;
            else if (s == 0) stage[s] <= d;
            else             stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];

    if (STAGES == 2) begin : g_chk
        for (genvar i = 0; i < N; i++) begin : g_bit
            a_r7_rise: assert property (@(posedge clk) disable iff (rst)
                $rose(q[i]) |-> $past(d[i], 2));
            a_r7_fall: assert property (@(posedge clk) disable iff (rst)
                $fell(q[i]) |-> !$past(d[i], 2));
        end
    end
endmodule

// File: rtl/xdom_flag.sv
module xdom_flag #(
    parameter int unsigned N           = 4,
    parameter int unsigned SYNC_STAGES = xflag_pkg::SYNC_STAGES_DEF
) (
    input  logic         set_clk,
    input  logic         set_rst,
    input  logic [N-1:0] set_en,
    input  logic         rd_clk,
    input  logic         rd_rst,
    input  logic [N-1:0] clr_en,
    output logic [N-1:0] flag_raw,
    output logic [N-1:0] flag_sync
);
    import xflag_pkg::*;

    logic [N-1:0] set_q;
    logic [N-1:0] clr_q;
    logic [N-1:0] clr_go;

    assign clr_go = clr_en & flag_sync;

    xflag_set_side #(.N(N)) u_set (
        .clk(set_clk), .rst(set_rst), .en(set_en), .peer_q(clr_q), .q(set_q)
    );

    xflag_clr_side #(.N(N)) u_clr (
        .clk(rd_clk), .rst(rd_rst), .en(clr_go), .peer_q(set_q), .q(clr_q)
    );

    for (genvar i = 0; i < N; i++) begin : g_flag
        flop_pair_t pr;
        assign pr.set_q   = set_q[i];
        assign pr.clr_q   = clr_q[i];
        assign flag_raw[i] = pair_flag(pr);
    end

    xflag_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(rd_clk), .rst(rd_rst), .d(flag_raw), .q(flag_sync)
    );

    a_r5_clear_equal: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_rst |=> ((clr_q ^ $past(set_q)) & $past(clr_en & flag_sync)) == '0);
    a_r6_clear_gated: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_rst |=> ((clr_q ^ $past(clr_q)) & ~$past(flag_sync)) == '0);
endmodule

// File: tb/xdom_flag_tb.sv
module xdom_flag_tb;
    localparam int N = 4;

    logic         set_clk = 1'b0;
    logic         set_rst = 1'b1;
    logic [N-1:0] set_en  = '0;
    logic         rd_clk  = 1'b0;
    logic         rd_rst  = 1'b1;
    logic [N-1:0] clr_en  = '0;
    logic [N-1:0] flag_raw;
    logic [N-1:0] flag_sync;

    int checks = 0;
    int errors = 0;

    xdom_flag #(.N(N)) u_dut (
        .set_clk(set_clk), .set_rst(set_rst), .set_en(set_en),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .clr_en(clr_en),
        .flag_raw(flag_raw), .flag_sync(flag_sync)
    );

    always #10 rd_clk = ~rd_clk;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_pulse(input logic [N-1:0] m, input int w);
        @(negedge rd_clk);
        #2 set_en = m;
        #1 set_clk = 1'b1;
        #(w) set_clk = 1'b0;
        #1 set_en = '0;
    endtask

    task automatic clr_req(input logic [N-1:0] m);
        @(negedge rd_clk);
        clr_en = m;
        @(posedge rd_clk);
        @(negedge rd_clk);
        clr_en = '0;
    endtask

    task automatic settle();
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic do_reset();
        set_rst = 1'b1;
        rd_rst  = 1'b1;
        repeat (3) set_pulse('0, 3);
        settle();
        set_rst = 1'b0;
        rd_rst  = 1'b0;
        @(negedge rd_clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 raw after reset", flag_raw, '0);
        chk("R1 sync after reset", flag_sync, '0);

        // R2 R3 R5 R8 R10 sweep of set mask against clear mask
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                set_pulse(p[N-1:0], 3);
                #1 chk("R2 R3 R8 raw after set", flag_raw, p[N-1:0]);
                settle();
                chk("R7 sync after set", flag_sync, p[N-1:0]);
                clr_req(m[N-1:0]);
                chk("R5 R10 R8 raw after clear", flag_raw, p[N-1:0] & ~m[N-1:0]);
                settle();
                chk("R7 sync after clear", flag_sync, p[N-1:0] & ~m[N-1:0]);
                clr_req('1);
                settle();
            end
        end

        // R4 double set
        set_pulse(4'b0100, 3);
        set_pulse(4'b0100, 3);
        #1 chk("R4 raw after second set", flag_raw, 4'b0100);
        settle();
        chk("R4 sync after second set", flag_sync, 4'b0100);
        clr_req('1);
        settle();
        chk("R5 cleared", flag_raw, '0);

        // R6 clear before sync catches up
        set_pulse(4'b0001, 3);
        clr_req(4'b0001);
        chk("R6 early clear ignored raw", flag_raw, 4'b0001);
        settle();
        chk("R6 sync after ignored clear", flag_sync, 4'b0001);
        clr_req(4'b0001);
        chk("R5 later clear raw", flag_raw, '0);
        settle();

        // R9 narrow strobe
        set_pulse(4'b1000, 1);
        #1 chk("R9 narrow strobe raw", flag_raw, 4'b1000);
        settle();
        chk("R9 narrow strobe sync", flag_sync, 4'b1000);

        // R1 reset mid-run
        set_pulse(4'b0110, 3);
        do_reset();
        chk("R1 raw after mid reset", flag_raw, '0);
        chk("R1 sync after mid reset", flag_sync, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule